// File: doc/BRIEF.md
# Capture/Compare Timer Flag Unit

This block runs a 16-bit free-running counter that advances by one on every clock after reset and wraps from FFFFh back to 0000h. Two capture channels each latch the counter value when their asynchronous input rises. Two compare registers are matched against the counter on every cycle. Each of these events, and the counter wrap, sets a sticky flag in a read-only status byte.

Software reaches every register through a byte-wide bus, with the high and low halves at separate addresses. A flag is cleared by a two-step handshake. First, software reads the status byte. Then it reads or writes the low byte that belongs to that flag. Only the flags that read as 1 in that status read are armed for clearing. A flag that is set later survives the low-byte access. When a set event and a clear land in the same cycle, the set wins.

A PWM qualifier input adds a second source for capture flag 1: a counter match against compare register 2.

Top module: `capcmp_timer`

## Requirements
- R1: After reset the status byte (address 0) reads 00h. Compare 1 reads 80h at its high byte (address 9) and 00h at its low byte (address 10). Status bits 2..0 always read 0. Read data appears on `bus_rdata` in the cycle after `bus_rd`.
- R2: The counter (high byte at address 1, low byte at address 2) holds 0 during reset and increases by one on every clock after reset. The alternate counter view (addresses 3 and 4) returns the same value.
- R3: Status bit 5 (wrap flag) sets when the counter goes from FFFFh to 0000h. It clears after a status read followed by an access to address 2. An access to address 4 leaves it unchanged.
- R4: Status bit 6 sets in the cycle after the counter equals compare 1 (addresses 9/10). It clears after a status read followed by an access to address 10. Without a preceding status read, that access has no effect.
- R5: Status bit 3 sets in the cycle after the counter equals compare 2 (addresses 11/12, reset FFFFh). It clears after a status read followed by an access to address 12.
- R6: Status bit 7 sets on a rising edge of `cap1_in`. It clears after a status read followed by an access to address 6.
- R7: Status bit 4 sets on a rising edge of `cap2_in`. It clears after a status read followed by an access to address 8.
- R8: With `pwm_mode` high, a counter match against compare 2 also sets status bit 7. With `pwm_mode` low, that match does not set bit 7.
- R9: A capture loads the full counter value into the capture register, read through addresses 5/6 (channel 1) and 7/8 (channel 2). The value loaded is the counter value two clocks after the input is first sampled high, because the input passes through a two-flop synchronizer.
- R10: A status read arms clearing only for the flags that read as 1. A flag set after that read stays set through the following low-byte access.
- R11: If a flag's set event coincides with its armed clearing access, the flag remains 1.
- R12: A capture input held high produces exactly one capture event. No further event occurs until the input falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_mode | input | 1 | Makes a compare-2 match also set capture flag 1 |
| cap1_in | input | 1 | Asynchronous capture input, channel 1 |
| cap2_in | input | 1 | Asynchronous capture input, channel 2 |
| bus_addr | input | 4 | Register byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
The bench targets the clear handshake.
- It accesses a low byte without a prior status read. A design that cleared on any access would drop the flag here.
- It lets a flag set between the status read and the low-byte access. A design that armed every flag would wrongly clear it.
- It times a capture edge to land on the very cycle of an armed clear. A design that let the clear win would drop the flag.

The bench also runs the counter through a full wrap. This checks that the alternate counter view does not clear the wrap flag. It holds a capture input high to catch level-triggered capture. It checks captured values against a counter model that accounts for the synchronizer delay, so an off-by-one stage count shows up as a wrong value.

// File: rtl/capcmp_timer_pkg.sv
`timescale 1ns/1ps
package capcmp_timer_pkg;
  localparam int NUM_FLAGS = 5;
  // flag indices; status byte = {flags, 3'b000}
  localparam int F_CMP2 = 0;
  localparam int F_CAP2 = 1;
  localparam int F_WRAP = 2;
  localparam int F_CMP1 = 3;
  localparam int F_CAP1 = 4;

  localparam logic [3:0] A_STAT    = 4'd0;
  localparam logic [3:0] A_CNT_HI  = 4'd1;
  localparam logic [3:0] A_CNT_LO  = 4'd2;
  localparam logic [3:0] A_ALT_HI  = 4'd3;
  localparam logic [3:0] A_ALT_LO  = 4'd4;
  localparam logic [3:0] A_CAP1_HI = 4'd5;
  localparam logic [3:0] A_CAP1_LO = 4'd6;
  localparam logic [3:0] A_CAP2_HI = 4'd7;
  localparam logic [3:0] A_CAP2_LO = 4'd8;
  localparam logic [3:0] A_CMP1_HI = 4'd9;
  localparam logic [3:0] A_CMP1_LO = 4'd10;
  localparam logic [3:0] A_CMP2_HI = 4'd11;
  localparam logic [3:0] A_CMP2_LO = 4'd12;
endpackage

// File: rtl/capcmp_edge_sync.sv
`timescale 1ns/1ps
module capcmp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  assert_single_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/capcmp_flag.sv
`timescale 1ns/1ps
module capcmp_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic stat_rd_i,
  input  logic clr_acc_i,
  output logic flag_o
);
  logic arm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      if (stat_rd_i)      arm_q <= flag_o;
      else if (clr_acc_i) arm_q <= 1'b0;
      if (set_i)                   flag_o <= 1'b1;
      else if (clr_acc_i && arm_q) flag_o <= 1'b0;
    end
  end

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    flag_o && !(clr_acc_i && arm_q) |=> flag_o);
  assert_unarmed_keep_R10: assert property (@(posedge clk) disable iff (rst)
    stat_rd_i && !flag_o && !set_i ##1 clr_acc_i |=> flag_o == $past(flag_o));
endmodule

// File: rtl/capcmp_timer.sv
`timescale 1ns/1ps
module capcmp_timer
  import capcmp_timer_pkg::*;
#(
  parameter int          BUS_W    = 8,
  parameter logic [31:0] CMP1_RST = 32'h0000_8000,
  parameter logic [31:0] CMP2_RST = 32'h0000_FFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwm_mode,
  input  logic             cap1_in,
  input  logic             cap2_in,
  input  logic [3:0]       bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata
);
  localparam int CNT_W  = 2 * BUS_W;
  localparam int NUM_CH = 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W-1:0]     cmp1_q, cmp2_q;
  logic [CNT_W-1:0]     cap_q [NUM_CH];
  logic [NUM_CH-1:0]    cap_pins, cap_rise;
  logic [NUM_FLAGS-1:0] flags, flag_set, flag_clr;
  logic                 bus_acc, stat_rd, hit1, hit2;
  logic [BUS_W-1:0]     status;

  // free-running counter
  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  // capture channels
  assign cap_pins = {cap2_in, cap1_in};
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cap
    capcmp_edge_sync #(.STAGES(2)) u_sync (
      .clk(clk), .rst(rst), .din(cap_pins[ch]), .rise_o(cap_rise[ch]));
    always_ff @(posedge clk) begin
      if (cap_rise[ch]) cap_q[ch] <= cnt_q;
    end
    assert_cap_load_R9: assert property (@(posedge clk) disable iff (rst)
      cap_rise[ch] |=> cap_q[ch] == $past(cnt_q));
  end

  // compare registers, byte writes
  always_ff @(posedge clk) begin
    if (rst) begin
      cmp1_q <= CMP1_RST[CNT_W-1:0];
      cmp2_q <= CMP2_RST[CNT_W-1:0];
    end else if (bus_wr) begin
      case (bus_addr)
        A_CMP1_HI: cmp1_q[CNT_W-1:BUS_W] <= bus_wdata;
        A_CMP1_LO: cmp1_q[BUS_W-1:0]     <= bus_wdata;
        A_CMP2_HI: cmp2_q[CNT_W-1:BUS_W] <= bus_wdata;
        A_CMP2_LO: cmp2_q[BUS_W-1:0]     <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign hit1    = (cnt_q == cmp1_q);
  assign hit2    = (cnt_q == cmp2_q);
  assign bus_acc = bus_rd | bus_wr;
  assign stat_rd = bus_rd && (bus_addr == A_STAT);

  always_comb begin
    flag_set         = '0;
    flag_set[F_CMP2] = hit2;
    flag_set[F_CAP2] = cap_rise[1];
    flag_set[F_WRAP] = (cnt_q == CNT_MAX);
    flag_set[F_CMP1] = hit1;
    flag_set[F_CAP1] = cap_rise[0] | (pwm_mode & hit2);
    flag_clr         = '0;
    flag_clr[F_CMP2] = bus_acc && (bus_addr == A_CMP2_LO);
    flag_clr[F_CAP2] = bus_acc && (bus_addr == A_CAP2_LO);
    flag_clr[F_WRAP] = bus_acc && (bus_addr == A_CNT_LO);
    flag_clr[F_CMP1] = bus_acc && (bus_addr == A_CMP1_LO);
    flag_clr[F_CAP1] = bus_acc && (bus_addr == A_CAP1_LO);
  end

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    capcmp_flag u_flag (
      .clk(clk), .rst(rst), .set_i(flag_set[f]), .stat_rd_i(stat_rd),
      .clr_acc_i(flag_clr[f]), .flag_o(flags[f]));
  end

  assign status = {flags, {(BUS_W-NUM_FLAGS){1'b0}}};

  // registered read mux
  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        A_STAT:              bus_rdata <= status;
        A_CNT_HI, A_ALT_HI:  bus_rdata <= cnt_q[CNT_W-1:BUS_W];
        A_CNT_LO, A_ALT_LO:  bus_rdata <= cnt_q[BUS_W-1:0];
        A_CAP1_HI:           bus_rdata <= cap_q[0][CNT_W-1:BUS_W];
        A_CAP1_LO:           bus_rdata <= cap_q[0][BUS_W-1:0];
        A_CAP2_HI:           bus_rdata <= cap_q[1][CNT_W-1:BUS_W];
        A_CAP2_LO:           bus_rdata <= cap_q[1][BUS_W-1:0];
        A_CMP1_HI:           bus_rdata <= cmp1_q[CNT_W-1:BUS_W];
        A_CMP1_LO:           bus_rdata <= cmp1_q[BUS_W-1:0];
        A_CMP2_HI:           bus_rdata <= cmp2_q[CNT_W-1:BUS_W];
        A_CMP2_LO:           bus_rdata <= cmp2_q[BUS_W-1:0];
        default:             bus_rdata <= '0;
      endcase
    end
  end

  assert_status_pad_R1: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> bus_rdata[2:0] == 3'b000);
  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q == CNT_MAX |=> flags[F_WRAP]);
  assert_pwm_set_R8: assert property (@(posedge clk) disable iff (rst)
    pwm_mode && hit2 |=> flags[F_CAP1]);
endmodule

// File: tb/capcmp_timer_test.sv
`timescale 1ns/1ps
module capcmp_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwm_mode = 1'b0, cap1_in = 1'b0, cap2_in = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [15:0] model = '0;
  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  capcmp_timer uut (
    .clk(clk), .rst(rst), .pwm_mode(pwm_mode), .cap1_in(cap1_in), .cap2_in(cap2_in),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  // independent counter model: value the design holds between edges
  always @(posedge clk) model <= rst ? 16'h0 : model + 16'h1;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d, output logic [15:0] m);
    bus_addr = a; bus_rd = 1'b1; m = model;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic stat_bit(input string tag, input int b, input logic exp);
    logic [7:0] d; logic [15:0] m;
    rd(4'd0, d, m);
    check(tag, {7'b0, d[b]}, {7'b0, exp});
  endtask

  task automatic wait_model(input logic [15:0] t);
    while (model != t) @(negedge clk);
  endtask

  task automatic set_cmp(input int ch, input logic [15:0] v);
    wr(ch == 1 ? 4'd9 : 4'd11, v[15:8]);
    wr(ch == 1 ? 4'd10 : 4'd12, v[7:0]);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2; logic [15:0] m, m2, t;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(4'd0, d, m);  check("R1 status after reset", d, 8'h00);
    rd(4'd9, d, m);  check("R1 cmp1 high reset", d, 8'h80);
    rd(4'd10, d, m); check("R1 cmp1 low reset", d, 8'h00);
    // R2 counter tracks cycles, alternate view agrees
    rd(4'd2, d, m);  check("R2 counter low", d, m[7:0]);
    rd(4'd1, d, m);  check("R2 counter high", d, m[15:8]);
    rd(4'd4, d, m);  check("R2 alt counter low", d, m[7:0]);
    rd(4'd3, d, m);  check("R2 alt counter high", d, m[15:8]);
    // R4/R5 compare matches, R8 negative with pwm low
    t = model + 16'd300;
    set_cmp(1, t); set_cmp(2, t + 16'd200);
    wait_model(t);
    stat_bit("R4 cmp1 not yet set", 6, 1'b0);
    wait_model(t + 16'd20);
    stat_bit("R4 cmp1 set after match", 6, 1'b1);
    stat_bit("R5 cmp2 not yet set", 3, 1'b0);
    wait_model(t + 16'd220);
    stat_bit("R5 cmp2 set after match", 3, 1'b1);
    rd(4'd0, d, m);
    check("R8 no cap1 flag from cmp2 when pwm low", {7'b0, d[7]}, 8'h0);
    check("R1 status low bits zero", {5'b0, d[2:0]}, 8'h0);
    // R4 clear handshake; R10 arm only flags read as 1
    rd(4'd10, d, m);                      // arm from status read above: set
    stat_bit("R4 cmp1 cleared after status+low access", 6, 1'b0);
    rd(4'd10, d, m);                      // status read above armed nothing for bit 6
    wr(4'd10, t[7:0]);
    stat_bit("R5 cmp2 kept while unarmed low access", 3, 1'b1);
    wr(4'd12, (t + 16'd200) & 16'hFF);    // status just read showed bit3=1
    stat_bit("R5 cmp2 cleared after status+low write", 3, 1'b0);
    // R10 flag set after status read survives
    rd(4'd0, d, m);
    check("R10 cap2 clear before pulse", {7'b0, d[4]}, 8'h0);
    cap2_in = 1'b1; repeat (5) @(negedge clk); cap2_in = 1'b0;
    rd(4'd8, d, m);
    stat_bit("R10 late-set cap2 flag survives access", 4, 1'b1);
    rd(4'd8, d, m);
    stat_bit("R7 cap2 cleared after handshake", 4, 1'b0);
    // R6/R9 capture channel 1 value
    m = model; cap1_in = 1'b1;
    repeat (6) @(negedge clk); cap1_in = 1'b0; repeat (4) @(negedge clk);
    m2 = m + 16'd2;
    rd(4'd5, d, t);  check("R9 cap1 high value", d, m2[15:8]);
    rd(4'd6, d2, t); check("R9 cap1 low value", d2, m2[7:0]);
    stat_bit("R6 cap1 flag set", 7, 1'b1);
    rd(4'd6, d, t);
    stat_bit("R6 cap1 cleared after handshake", 7, 1'b0);
    // R9 channel 2 value
    m = model; cap2_in = 1'b1;
    repeat (4) @(negedge clk); cap2_in = 1'b0; repeat (3) @(negedge clk);
    m2 = m + 16'd2;
    rd(4'd7, d, t);  check("R9 cap2 high value", d, m2[15:8]);
    rd(4'd8, d2, t); check("R9 cap2 low value", d2, m2[7:0]);
    // R12 held input fires once
    stat_bit("R12 prep status read", 4, 1'b1);
    rd(4'd8, d, t);
    cap1_in = 1'b1; repeat (4) @(negedge clk);
    stat_bit("R12 cap1 set by edge", 7, 1'b1);
    rd(4'd6, d, t);
    repeat (10) @(negedge clk);
    stat_bit("R12 held high no re-trigger", 7, 1'b0);
    cap1_in = 1'b0; repeat (4) @(negedge clk);
    // R11 set coincides with armed clear
    cap1_in = 1'b1; repeat (4) @(negedge clk); cap1_in = 1'b0; repeat (4) @(negedge clk);
    stat_bit("R11 prep cap1 set and armed", 7, 1'b1);
    cap1_in = 1'b1;
    repeat (2) @(negedge clk);
    rd(4'd6, d, t);                       // access lands on the capture edge
    cap1_in = 1'b0;
    stat_bit("R11 set wins over clear", 7, 1'b1);
    rd(4'd6, d, t);
    stat_bit("R11 cleared afterwards", 7, 1'b0);
    // R8 pwm mode
    pwm_mode = 1'b1;
    t = model + 16'd100; set_cmp(2, t);
    wait_model(t + 16'd10);
    stat_bit("R8 cap1 set by cmp2 match in pwm", 7, 1'b1);
    pwm_mode = 1'b0;
    rd(4'd6, d, m2);
    // R3 wrap flag
    stat_bit("R3 wrap clear before overflow", 5, 1'b0);
    wait_model(16'hFFF0);
    wait_model(16'h0005);
    stat_bit("R3 wrap set after overflow", 5, 1'b1);
    rd(4'd4, d, m);
    stat_bit("R3 alt low access keeps wrap", 5, 1'b1);
    rd(4'd2, d, m);
    stat_bit("R3 wrap cleared via counter low", 5, 1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule